// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block gathers the digital protection flags of a three-phase gate driver and turns them into three outputs. The first is a fault indication, active high, meant for an open-drain pin. The second is a request to coast with every power switch off. The third is a request that kills only the high-side switches. The analog comparators and their hysteresis sit outside the block, so each arrives here as a synchronous flag.

The invalid Hall code, regulator undervoltage and over-temperature flags are taken as already hysteretic. Each one acts live: the block registers it for one cycle and holds nothing beyond that. A lead-to-ground short is handled differently. It counts only while that phase's high-side switch is on, and it must hold for a programmable number of consecutive cycles. Once that happens, a latch sets and asks for the high side to be killed while the low side keeps running. The latch clears on every commutation pulse, and it also clears while the driver's disable input is high, so toggling that input recovers a stalled motor.

Top module: `motor_fault_supervisor`

## Requirements
- R1: `faultOut` is high one cycle after any of `hallBad`, `regLow` or `overTemp` is sampled high, and it is high whenever the short latch of any phase is set.
- R2: `coastReq` is high exactly one cycle after any of `hallBad`, `regLow` or `overTemp` is sampled high, and it drops one cycle after all three are sampled low. These faults are not latched.
- R3: A latched short raises `highKillReq` and `faultOut` but never raises `coastReq`.
- R4: Phase i's `gndShort[i]` is ignored in every cycle where `highOn[i]` is low. In such a cycle it neither advances nor sets that phase's latch, and its run of consecutive cycles restarts.
- R5: A phase's latch sets, and `highKillReq` rises, one cycle after the SHORT_CYCLES-th consecutive sampled cycle with both `gndShort[i]` and `highOn[i]` high. A gap restarts the count.
- R6: Once set, the latch keeps `highKillReq` high after the comparator flag drops, until a clear occurs.
- R7: A cycle with `commPulse` high clears every latch and run counter, so `highKillReq` is low in the next cycle. The clear wins over a set in the same cycle.
- R8: A cycle with `driveReset` high clears every latch and run counter in the same way as R7.
- R9: While `rst_n` is low, and after its release until the first clock edge, all three outputs are low. The first edge after release makes them follow the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| hallBad | input | 1 | Invalid Hall code flag |
| regLow | input | 1 | Gate regulator undervoltage flag (hysteretic) |
| overTemp | input | 1 | Thermal shutdown flag (hysteretic) |
| gndShort | input | NPH | Per-phase lead-to-ground comparator flags |
| highOn | input | NPH | Per-phase high-side switch on indication |
| commPulse | input | 1 | One-cycle commutation event |
| driveReset | input | 1 | Driver disable input, high = disabled; clears the short latch |
| faultOut | output | 1 | Fault indication, high = fault |
| coastReq | output | 1 | Request to turn off all power switches |
| highKillReq | output | 1 | Request to turn off only the high-side switches |

## Verification
The bench aims first at the count boundary. A short held for one cycle fewer than SHORT_CYCLES must leave the latch clear, and a design with an off-by-one would either kill the high side one cycle early or demand an extra cycle. It also holds a short while the high side is off, where a design that forgot the qualifier would latch. A clear is made to coincide with the final qualifying cycle, where a design with the wrong priority would leave the kill set. The live faults are dropped to show they do not stick, and a latched short is checked to raise no coast request, which would catch a design that merged the two responses.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clrShort;  // wipe run counters and latches this cycle
    logic liveSet;   // any non-latched fault present this cycle
  } fsupStrobe_t;
endpackage

// File: rtl/fsup_ctrl.sv
module fsup_ctrl
  import fsup_pkg::*;
#(
  parameter int NPH = 3
) (
  input  logic           hallBad,
  input  logic           regLow,
  input  logic           overTemp,
  input  logic [NPH-1:0] gndShort,
  input  logic [NPH-1:0] highOn,
  input  logic           commPulse,
  input  logic           driveReset,
  output fsupStrobe_t    strobes,
  output logic [NPH-1:0] qual
);
  always_comb begin
    strobes.clrShort = commPulse | driveReset;
    strobes.liveSet  = hallBad | regLow | overTemp;
  end

  // comparator is only meaningful while the high side conducts
  assign qual = gndShort & highOn;
endmodule

// File: rtl/fsup_datapath.sv
module fsup_datapath
  import fsup_pkg::*;
#(
  parameter int NPH         = 3,
  parameter int SHORT_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  fsupStrobe_t    strobes,
  input  logic [NPH-1:0] qual,
  output logic           liveFault,
  output logic [NPH-1:0] shortLatch
);
  localparam int CW = (SHORT_CYCLES < 2) ? 1 : $clog2(SHORT_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(SHORT_CYCLES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) liveFault <= 1'b0;
    else        liveFault <= strobes.liveSet;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_phase
    logic [CW-1:0] runCnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        runCnt        <= '0;
        shortLatch[i] <= 1'b0;
      end else if (strobes.clrShort) begin
        runCnt        <= '0;
        shortLatch[i] <= 1'b0;
      end else if (qual[i]) begin
        if (runCnt == LAST) shortLatch[i] <= 1'b1;
        else                runCnt        <= runCnt + 1'b1;
      end else begin
        runCnt <= '0;
      end
    end

    // R4
    no_unqual_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!qual[i] && !shortLatch[i]) |=> !shortLatch[i]);
  end

  // R7
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrShort |=> (shortLatch == '0));

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.clrShort |=> ((shortLatch & $past(shortLatch)) == $past(shortLatch)));

  // R2
  live_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.liveSet |=> liveFault);
endmodule

// File: rtl/motor_fault_supervisor.sv
module motor_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int NPH          = 3,
  parameter int SHORT_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hallBad,
  input  logic           regLow,
  input  logic           overTemp,
  input  logic [NPH-1:0] gndShort,
  input  logic [NPH-1:0] highOn,
  input  logic           commPulse,
  input  logic           driveReset,
  output logic           faultOut,
  output logic           coastReq,
  output logic           highKillReq
);
  fsupStrobe_t    strobes;
  logic [NPH-1:0] qual;
  logic           liveFault;
  logic [NPH-1:0] shortLatch;

  fsup_ctrl #(.NPH(NPH)) u_ctrl (
    .hallBad(hallBad), .regLow(regLow), .overTemp(overTemp),
    .gndShort(gndShort), .highOn(highOn),
    .commPulse(commPulse), .driveReset(driveReset),
    .strobes(strobes), .qual(qual)
  );

  fsup_datapath #(.NPH(NPH), .SHORT_CYCLES(SHORT_CYCLES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .qual(qual),
    .liveFault(liveFault), .shortLatch(shortLatch)
  );

  assign coastReq    = liveFault;
  assign highKillReq = |shortLatch;
  assign faultOut    = liveFault | highKillReq;

  // R1
  kill_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    highKillReq |-> faultOut);

  // R1
  coast_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coastReq |-> faultOut);

  // R3
  short_no_coast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hallBad || regLow || overTemp) |=> !coastReq);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    driveReset |=> !highKillReq);
endmodule

// File: tb/tb_motor_fault_supervisor.sv
`timescale 1ns/1ps
module tb_motor_fault_supervisor;
  localparam int NPH = 3;
  localparam int N   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hallBad = 0, regLow = 0, overTemp = 0, commPulse = 0, driveReset = 0;
  logic [NPH-1:0] gndShort = '0, highOn = '0;
  logic faultOut, coastReq, highKillReq;

  int checks = 0, failures = 0, cycles = 0;

  // reference model state
  int  runLen [NPH];
  bit  latched [NPH];
  bit  mLive = 0;
  bit  mRstSeen = 0;

  always #2 clk = ~clk;  // 250 MHz

  motor_fault_supervisor #(.NPH(NPH), .SHORT_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .hallBad(hallBad), .regLow(regLow),
    .overTemp(overTemp), .gndShort(gndShort), .highOn(highOn),
    .commPulse(commPulse), .driveReset(driveReset),
    .faultOut(faultOut), .coastReq(coastReq), .highKillReq(highKillReq)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit anyLatch();
    bit r = 0;
    for (int i = 0; i < NPH; i++) r |= latched[i];
    return r;
  endfunction

  // model updated on each edge, compared shortly after
  always begin
    @(posedge clk);
    cycles++;
    if (!rst_n) begin
      mLive = 0;
      for (int i = 0; i < NPH; i++) begin runLen[i] = 0; latched[i] = 0; end
    end else begin
      mLive = hallBad | regLow | overTemp;
      for (int i = 0; i < NPH; i++) begin
        if (commPulse || driveReset) begin runLen[i] = 0; latched[i] = 0; end
        else if (gndShort[i] && highOn[i]) begin
          runLen[i]++;
          if (runLen[i] >= N) latched[i] = 1;
        end else runLen[i] = 0;
      end
    end
    #1;
    if (rst_n) begin
      check("R2 coastReq", coastReq, mLive);
      check("R5 highKillReq", highKillReq, anyLatch());
      check("R1 faultOut", faultOut, mLive | anyLatch());
    end
  end

  always @(posedge clk) if (cycles > 100000) begin
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    hallBad = 1;
    cyc(3);
    // R9: reset holds outputs low
    check("R9 coast in reset", coastReq, 1'b0);
    check("R9 fault in reset", faultOut, 1'b0);
    check("R9 kill in reset", highKillReq, 1'b0);
    rst_n = 1;
    #0.5;
    check("R9 coast before first edge", coastReq, 1'b0);
    cyc(1);
    check("R9 coast after first edge", coastReq, 1'b1);
    hallBad = 0; cyc(1);
    check("R2 hall not latched", coastReq, 1'b0);
    regLow = 1; cyc(1);
    check("R2 undervoltage coast", coastReq, 1'b1);
    regLow = 0; overTemp = 1; cyc(1);
    check("R1 thermal fault", faultOut, 1'b1);
    overTemp = 0; cyc(1);
    check("R1 fault clears", faultOut, 1'b0);

    // R4: short with high side off
    gndShort = 3'b001; highOn = 3'b000; cyc(10);
    check("R4 unqualified ignored", highKillReq, 1'b0);
    // R4: gap in qualifier restarts run
    highOn = 3'b001; cyc(N-1); highOn = 3'b000; cyc(1); highOn = 3'b001; cyc(N-1);
    check("R4 restart after high-side gap", highKillReq, 1'b0);
    gndShort = 3'b000; cyc(1);
    // R5: one short of the count
    gndShort = 3'b010; highOn = 3'b010; cyc(N-1);
    check("R5 N-1 cycles no latch", highKillReq, 1'b0);
    cyc(1);
    check("R5 N cycles latch", highKillReq, 1'b1);
    check("R3 short no coast", coastReq, 1'b0);
    check("R1 short raises fault", faultOut, 1'b1);
    gndShort = 3'b000; cyc(5);
    check("R6 latch holds", highKillReq, 1'b1);
    commPulse = 1; cyc(1); commPulse = 0;
    check("R7 commutation clears", highKillReq, 1'b0);
    // R7: clear coincides with final qualifying cycle
    gndShort = 3'b100; highOn = 3'b100; cyc(N-1);
    commPulse = 1; cyc(1); commPulse = 0;
    check("R7 clear wins over set", highKillReq, 1'b0);
    cyc(N);
    check("R7 count restarted then latched", highKillReq, 1'b1);
    gndShort = 3'b000;
    // R8
    driveReset = 1; cyc(1);
    check("R8 driveReset clears", highKillReq, 1'b0);
    driveReset = 0; cyc(1);
    check("R8 stays clear", highKillReq, 1'b0);
    // mixed: short latched plus live fault
    gndShort = 3'b001; highOn = 3'b001; cyc(N); gndShort = 0;
    hallBad = 1; cyc(1);
    check("R2 coast with latched short", coastReq, 1'b1);
    hallBad = 0; cyc(1);
    check("R3 coast drops, kill held", highKillReq & ~coastReq, 1'b1);
    cyc(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule